// File: doc/BRIEF.md
# TDM System-Port Channel Interface

This block joins a line transceiver to a serial time-division backplane. The backplane runs at 2048 kbit/s with a 4096 kHz bit clock (two clock cycles per data bit) and an active-low 8 kHz frame pulse. Each frame holds 32 eight-bit channels, sent most significant bit first. The block takes the transceiver's four channels out of the incoming stream and presents them as parallel bytes. These are the 2-bit D signalling channel, the C control channel, and the two 8-bit bearer channels B1 and B2. It also serialises the transmit bytes back onto the outgoing stream.

Two port mappings exist. In single-port mode all four channels share the main data pair. In dual-port mode the main pair carries only B1 and B2, and a second pair carries D and C. Each data output has an enable that is high only in the block's own slots, so the pad can be tri-stated in every other slot. An active-low delayed frame pulse lets the next device on a shared backplane start its own channel times. The C byte received from the backplane issues a write pulse for one of three control registers. It also selects which of four status bytes is sent back in the transmit C slot.

Top module: `tdm_port`

## Requirements
- R1: A low `fp_n` sampled at a rising edge makes the next cycle the first half of bit 7 of channel 0. A frame is 512 cycles: 32 channels of 8 bits, 2 cycles per bit. With no pulse the count wraps on its own, and any pulse realigns it at once.
- R2: After reset and before the first frame pulse, both enables stay low, `rx_strobe` stays low and `dfp_n` stays high.
- R3: Single mode (`dual`=0) maps the main pair as follows: channel 0 is D, 1 is C, 2 is B1 and 3 is B2. `main_oe` is high only in channels 0 to 3, and `aux_oe` is never high.
- R4: Dual mode (`dual`=1) maps the main pair as channel 0 B1 and channel 1 B2. The second pair carries channel 0 D and channel 1 C. Both enables are high only in channels 0 and 1.
- R5: Each input bit is sampled at the rising edge that ends the first of its two cycles. Transmit bits change only on bit boundaries.
- R6: The transmit bytes `tx_d`, `tx_b1`, `tx_b2` and the status byte are captured at the edge that starts a frame (count going to 0). Later changes within that frame do not reach the outputs.
- R7: The transmitted D slot carries `tx_d` in its two first bits and ones in the six reserved bits. The received `rx_d` is the first two bits of the D slot, and the six reserved bits have no effect on it.
- R8: `rx_strobe` is high for exactly one cycle per frame. That cycle is the one after the last bit of the last active channel is sampled: frame position 63 in single mode, 31 in dual mode. `rx_d`, `rx_c`, `rx_b1` and `rx_b2` change only in that cycle and show that frame's bytes.
- R9: Received C bits [7:6] select a control write. Code 01 pulses `ctrl_wr[0]`, 10 pulses `ctrl_wr[1]` and 11 pulses `ctrl_wr[2]`, each together with `rx_strobe`. Code 00 pulses nothing. C bits [5:4] set `stat_sel`, which holds until the next strobe. At each frame start, byte `stat_bank[8*stat_sel +: 8]` is loaded for the transmit C slot.
- R10: `dfp_n` is low for exactly one cycle per synchronised frame. In single mode that is the last cycle of channel 3 (position 63). In dual mode it is the last cycle of channel 0 (position 15).
- R11: A synchronous active-low `rst_n` clears all outputs and returns the block to the unsynchronised state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4096 kHz bit clock |
| rst_n | input | 1 | synchronous reset, active low |
| fp_n | input | 1 | frame pulse, active low, one cycle |
| dual | input | 1 | 0 single-port mapping, 1 dual-port mapping |
| main_in | input | 1 | main serial data input |
| aux_in | input | 1 | second-pair serial data input |
| tx_d | input | 2 | D bits to send |
| tx_b1 | input | 8 | B1 byte to send |
| tx_b2 | input | 8 | B2 byte to send |
| stat_bank | input | 32 | four status bytes, byte k at bits 8k+7..8k |
| main_out | output | 1 | main serial data output |
| main_oe | output | 1 | main output drive enable |
| aux_out | output | 1 | second-pair serial data output |
| aux_oe | output | 1 | second-pair drive enable |
| dfp_n | output | 1 | delayed frame pulse for the next device, active low |
| rx_strobe | output | 1 | received bytes updated this cycle |
| rx_d | output | 2 | received D bits |
| rx_c | output | 8 | received C byte |
| rx_b1 | output | 8 | received B1 byte |
| rx_b2 | output | 8 | received B2 byte |
| ctrl_wr | output | 3 | one-hot control register write pulses |
| stat_sel | output | 2 | status byte selected for read-back |

## Verification
The bench targets several corner cases:
- **Switching mapping at a frame boundary.** A block that kept the old slot map would drive the wrong pair or leave channels 2 and 3 driven in dual mode.
- **A frame pulse arriving early in the frame.** A counter that ignored realignment would move every slot and the delayed pulse.
- **Free-running frames with no pulse.** A counter that stalled would stop driving.
- **Transmit bytes and the status bank changing every cycle.** A framer that read them live instead of at frame start would corrupt bytes mid-frame.
- **Random D reserved bits and every C code.** A decoder that took the wrong bits would show wrong `rx_d`, write pulses or status selection.
- **A reset in the middle of a run.** A block that kept its alignment would drive before the next pulse.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_W  = $clog2(BYTE_W);
    localparam int unsigned D_BITS = 2;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned N_CTRL = 3;
    localparam int unsigned N_STAT = 4;
    localparam int unsigned N_PAIR = 2;   // 0 = main pair, 1 = second pair

    typedef enum logic [2:0] {
        SLOT_IDLE,
        SLOT_D,
        SLOT_C,
        SLOT_B1,
        SLOT_B2
    } slot_e;

    typedef struct packed {
        logic [D_BITS-1:0] d;
        logic [BYTE_W-1:0] c;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b2;
    } chan_set_t;

    // Which logical channel a pair carries in a given backplane channel.
    function automatic slot_e slot_of(input int unsigned pair, input logic dual,
                                      input int unsigned ch);
        slot_e k;
        k = SLOT_IDLE;
        if (dual) begin
            case (ch)
                0:       k = (pair == 0) ? SLOT_B1 : SLOT_D;
                1:       k = (pair == 0) ? SLOT_B2 : SLOT_C;
                default: k = SLOT_IDLE;
            endcase
        end else if (pair == 0) begin
            case (ch)
                0:       k = SLOT_D;
                1:       k = SLOT_C;
                2:       k = SLOT_B1;
                3:       k = SLOT_B2;
                default: k = SLOT_IDLE;
            endcase
        end
        return k;
    endfunction

    function automatic int unsigned last_chan(input logic dual);
        return dual ? 1 : 3;
    endfunction

    function automatic chan_set_t place(input chan_set_t s, input slot_e k,
                                        input logic [BYTE_W-1:0] b);
        chan_set_t r;
        r = s;
        case (k)
            SLOT_D:  r.d  = b[BYTE_W-1 -: D_BITS];
            SLOT_C:  r.c  = b;
            SLOT_B1: r.b1 = b;
            SLOT_B2: r.b2 = b;
            default: r    = s;
        endcase
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] slot_byte(input chan_set_t s, input slot_e k);
        logic [BYTE_W-1:0] b;
        case (k)
            SLOT_D:  b = {s.d, {(BYTE_W-D_BITS){1'b1}}};
            SLOT_C:  b = s.c;
            SLOT_B1: b = s.b1;
            SLOT_B2: b = s.b2;
            default: b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_port_pkg::*;
#(
    parameter int unsigned N_CH           = 32,
    parameter int unsigned CNT_W          = 9,
    parameter int unsigned SINGLE_MARK_CH = 3,
    parameter int unsigned DUAL_MARK_CH   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_n,
    input  logic             dual,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             sync_q_o,
    output logic             sync_d_o,
    output logic             dfp_n
);

    localparam int unsigned CH_CYC    = BYTE_W * 2;
    localparam int unsigned FRAME_CYC = N_CH * CH_CYC;
    localparam logic [CNT_W-1:0] LAST_POS   = CNT_W'(FRAME_CYC - 1);
    localparam logic [CNT_W-1:0] SINGLE_END = CNT_W'((SINGLE_MARK_CH + 1) * CH_CYC - 1);
    localparam logic [CNT_W-1:0] DUAL_END   = CNT_W'((DUAL_MARK_CH + 1) * CH_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sync;
        logic             dfp_n;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!fp_n) begin
            tmr_d.cnt  = '0;
            tmr_d.sync = 1'b1;
        end else if (tmr_q.sync) begin
            tmr_d.cnt = (tmr_q.cnt == LAST_POS) ? '0 : tmr_q.cnt + 1'b1;
        end
        tmr_d.dfp_n = !(tmr_d.sync && (tmr_d.cnt == (dual ? DUAL_END : SINGLE_END)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '{cnt: '0, sync: 1'b0, dfp_n: 1'b1};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cnt_q_o  = tmr_q.cnt;
    assign cnt_d_o  = tmr_d.cnt;
    assign sync_q_o = tmr_q.sync;
    assign sync_d_o = tmr_d.sync;
    assign dfp_n    = tmr_q.dfp_n;

endmodule

// File: rtl/tdm_rx_deframer.sv
module tdm_rx_deframer
    import tdm_port_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sync,
    input  logic [N_PAIR-1:0] din,
    output chan_set_t         rx,
    output logic              strobe,
    output logic [N_CTRL-1:0] ctrl_wr,
    output logic [SEL_W-1:0]  stat_sel
);

    typedef struct packed {
        logic [N_PAIR-1:0][BYTE_W-1:0] sh;
        chan_set_t                     stage;
        chan_set_t                     pub;
        logic                          strobe;
        logic [N_CTRL-1:0]             ctrl_wr;
        logic [SEL_W-1:0]              stat_sel;
    } rx_t;

    rx_t rx_d, rx_q;

    logic [N_PAIR-1:0][BYTE_W-1:0] byte_in;
    logic                          sample;
    logic                          last_bit;
    int unsigned                   ch;
    logic [SEL_W-1:0]              wcode;

    always_comb begin
        rx_d         = rx_q;
        rx_d.strobe  = 1'b0;
        rx_d.ctrl_wr = '0;
        sample       = sync && !cnt[0];
        last_bit     = (cnt[BIT_W:1] == BIT_W'(BYTE_W - 1));
        ch           = int'(cnt[CNT_W-1:BIT_W+1]);
        wcode        = '0;
        for (int p = 0; p < N_PAIR; p++) begin
            byte_in[p] = {rx_q.sh[p][BYTE_W-2:0], din[p]};
        end
        if (sample) begin
            rx_d.sh = byte_in;
            if (last_bit) begin
                for (int p = 0; p < N_PAIR; p++) begin
                    rx_d.stage = place(rx_d.stage, slot_of(p, dual, ch), byte_in[p]);
                end
                if (ch == last_chan(dual)) begin
                    rx_d.pub      = rx_d.stage;
                    rx_d.strobe   = 1'b1;
                    // C byte: [7:6] control write code, [5:4] status select
                    wcode         = rx_d.stage.c[BYTE_W-1 -: SEL_W];
                    rx_d.stat_sel = rx_d.stage.c[BYTE_W-1-SEL_W -: SEL_W];
                    if (wcode != '0) begin
                        rx_d.ctrl_wr = N_CTRL'(1) << (int'(wcode) - 1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx       = rx_q.pub;
    assign strobe   = rx_q.strobe;
    assign ctrl_wr  = rx_q.ctrl_wr;
    assign stat_sel = rx_q.stat_sel;

endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
    import tdm_port_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dual,
    input  logic [CNT_W-1:0]         cnt_nx,
    input  logic                     sync_nx,
    input  logic [D_BITS-1:0]        tx_d,
    input  logic [BYTE_W-1:0]        tx_b1,
    input  logic [BYTE_W-1:0]        tx_b2,
    input  logic [N_STAT*BYTE_W-1:0] stat_bank,
    input  logic [SEL_W-1:0]         stat_sel,
    output logic [N_PAIR-1:0]        dout,
    output logic [N_PAIR-1:0]        doe
);

    typedef struct packed {
        chan_set_t         shadow;
        logic [N_PAIR-1:0] dout;
        logic [N_PAIR-1:0] doe;
    } tx_t;

    tx_t tx_d_s, tx_q;

    int unsigned       ch;
    int unsigned       bi;
    slot_e             kind;
    logic [BYTE_W-1:0] cur;

    always_comb begin
        tx_d_s = tx_q;
        ch     = int'(cnt_nx[CNT_W-1:BIT_W+1]);
        bi     = int'(cnt_nx[BIT_W:1]);
        kind   = SLOT_IDLE;
        cur    = '0;
        if (sync_nx && (cnt_nx == '0)) begin
            tx_d_s.shadow.d  = tx_d;
            tx_d_s.shadow.c  = stat_bank[int'(stat_sel)*BYTE_W +: BYTE_W];
            tx_d_s.shadow.b1 = tx_b1;
            tx_d_s.shadow.b2 = tx_b2;
        end
        for (int p = 0; p < N_PAIR; p++) begin
            kind           = slot_of(p, dual, ch);
            cur            = slot_byte(tx_d_s.shadow, kind);
            tx_d_s.doe[p]  = sync_nx && (kind != SLOT_IDLE);
            tx_d_s.dout[p] = tx_d_s.doe[p] && cur[BYTE_W-1-bi];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d_s;
        end
    end

    assign dout = tx_q.dout;
    assign doe  = tx_q.doe;

endmodule

// File: rtl/tdm_port.sv
module tdm_port
    import tdm_port_pkg::*;
#(
    parameter int unsigned N_CH           = 32,
    parameter int unsigned SINGLE_MARK_CH = 3,
    parameter int unsigned DUAL_MARK_CH   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fp_n,
    input  logic                     dual,
    input  logic                     main_in,
    input  logic                     aux_in,
    input  logic [D_BITS-1:0]        tx_d,
    input  logic [BYTE_W-1:0]        tx_b1,
    input  logic [BYTE_W-1:0]        tx_b2,
    input  logic [N_STAT*BYTE_W-1:0] stat_bank,
    output logic                     main_out,
    output logic                     main_oe,
    output logic                     aux_out,
    output logic                     aux_oe,
    output logic                     dfp_n,
    output logic                     rx_strobe,
    output logic [D_BITS-1:0]        rx_d,
    output logic [BYTE_W-1:0]        rx_c,
    output logic [BYTE_W-1:0]        rx_b1,
    output logic [BYTE_W-1:0]        rx_b2,
    output logic [N_CTRL-1:0]        ctrl_wr,
    output logic [SEL_W-1:0]         stat_sel
);

    localparam int unsigned CNT_W = $clog2(N_CH * BYTE_W * 2);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic              sync_q;
    logic              sync_nx;
    chan_set_t         rx_set;
    logic [N_PAIR-1:0] tx_bits;
    logic [N_PAIR-1:0] tx_en;

    tdm_frame_timer #(
        .N_CH          (N_CH),
        .CNT_W         (CNT_W),
        .SINGLE_MARK_CH(SINGLE_MARK_CH),
        .DUAL_MARK_CH  (DUAL_MARK_CH)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fp_n    (fp_n),
        .dual    (dual),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_nx),
        .sync_q_o(sync_q),
        .sync_d_o(sync_nx),
        .dfp_n   (dfp_n)
    );

    tdm_rx_deframer #(
        .CNT_W(CNT_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .dual    (dual),
        .cnt     (cnt_q),
        .sync    (sync_q),
        .din     ({aux_in, main_in}),
        .rx      (rx_set),
        .strobe  (rx_strobe),
        .ctrl_wr (ctrl_wr),
        .stat_sel(stat_sel)
    );

    tdm_tx_framer #(
        .CNT_W(CNT_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .dual     (dual),
        .cnt_nx   (cnt_nx),
        .sync_nx  (sync_nx),
        .tx_d     (tx_d),
        .tx_b1    (tx_b1),
        .tx_b2    (tx_b2),
        .stat_bank(stat_bank),
        .stat_sel (stat_sel),
        .dout     (tx_bits),
        .doe      (tx_en)
    );

    assign main_out = tx_bits[0];
    assign aux_out  = tx_bits[1];
    assign main_oe  = tx_en[0];
    assign aux_oe   = tx_en[1];
    assign rx_d     = rx_set.d;
    assign rx_c     = rx_set.c;
    assign rx_b1    = rx_set.b1;
    assign rx_b2    = rx_set.b2;

endmodule

// File: rtl/tdm_port_chk.sv
module tdm_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dual,
    input logic       main_oe,
    input logic       aux_oe,
    input logic       dfp_n,
    input logic       rx_strobe,
    input logic [2:0] ctrl_wr
);

    AST_DFP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dfp_n |=> dfp_n); // R10

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe); // R8

    AST_CTRL_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctrl_wr)); // R9

    AST_CTRL_WR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr != 3'b000) |-> rx_strobe); // R9

    AST_AUX_IDLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual && $past(!dual)) |-> !aux_oe); // R3

    AST_AUX_WITH_MAIN_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && $past(dual) && aux_oe) |-> main_oe); // R4

endmodule

bind tdm_port tdm_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual     (dual),
    .main_oe  (main_oe),
    .aux_oe   (aux_oe),
    .dfp_n    (dfp_n),
    .rx_strobe(rx_strobe),
    .ctrl_wr  (ctrl_wr)
);

// File: tb/tb_tdm_port.sv
module tb_tdm_port;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, fp_n = 1'b1, dual = 1'b0, main_in = 1'b0, aux_in = 1'b0;
    logic [1:0]  tx_d = '0;
    logic [7:0]  tx_b1 = '0, tx_b2 = '0;
    logic [31:0] stat_bank = '0;
    logic        main_out, main_oe, aux_out, aux_oe, dfp_n, rx_strobe;
    logic [1:0]  rx_d, stat_sel;
    logic [7:0]  rx_c, rx_b1, rx_b2;
    logic [2:0]  ctrl_wr;

    tdm_port dut (
        .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .dual(dual),
        .main_in(main_in), .aux_in(aux_in), .tx_d(tx_d), .tx_b1(tx_b1),
        .tx_b2(tx_b2), .stat_bank(stat_bank), .main_out(main_out),
        .main_oe(main_oe), .aux_out(aux_out), .aux_oe(aux_oe), .dfp_n(dfp_n),
        .rx_strobe(rx_strobe), .rx_d(rx_d), .rx_c(rx_c), .rx_b1(rx_b1),
        .rx_b2(rx_b2), .ctrl_wr(ctrl_wr), .stat_sel(stat_sel)
    );

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    int         pos = 0;
    bit         syn = 0;
    logic [7:0] mb [0:31];
    logic [7:0] ab [0:31];
    logic [1:0] e_d = 0, e_sel = 0, s_d = 0;
    logic [7:0] e_c = 0, e_b1 = 0, e_b2 = 0, s_c = 0, s_b1 = 0, s_b2 = 0;
    logic [2:0] e_ctrl = 0;
    bit         e_strobe = 0, e_moe = 0, e_mout = 0, e_aoe = 0, e_aout = 0, e_dfp = 1;

    // role codes: 0 idle, 1 D, 2 C, 3 B1, 4 B2
    function automatic int role(bit aux, bit dl, int ch);
        if (dl) begin
            if (ch == 0) return aux ? 1 : 3;
            if (ch == 1) return aux ? 2 : 4;
            return 0;
        end
        if (aux || ch > 3) return 0;
        return ch + 1;
    endfunction

    function automatic logic [7:0] role_byte(int r);
        if (r == 1) return {s_d, 6'b111111};
        if (r == 2) return s_c;
        if (r == 3) return s_b1;
        if (r == 4) return s_b2;
        return 8'h00;
    endfunction

    task automatic model_update();
        int ch, b, rm, ra;
        logic [1:0] old_sel;
        logic [7:0] mbyte, abyte;
        e_strobe = 0;
        e_ctrl   = 0;
        if (!rst_n) begin
            pos = 0; syn = 0; e_d = 0; e_c = 0; e_b1 = 0; e_b2 = 0; e_sel = 0;
            s_d = 0; s_c = 0; s_b1 = 0; s_b2 = 0;
            e_moe = 0; e_mout = 0; e_aoe = 0; e_aout = 0; e_dfp = 1;
            return;
        end
        old_sel = e_sel;
        if (syn && (pos % 2 == 0)) begin
            b  = (pos / 2) % 8;
            ch = pos / 16;
            mb[ch][7-b] = main_in;
            ab[ch][7-b] = aux_in;
            if (b == 7 && ch == (dual ? 1 : 3)) begin
                e_d  = dual ? ab[0][7:6] : mb[0][7:6];
                e_c  = dual ? ab[1] : mb[1];
                e_b1 = dual ? mb[0] : mb[2];
                e_b2 = dual ? mb[1] : mb[3];
                e_strobe = 1;
                e_sel    = e_c[5:4];
                e_ctrl   = (e_c[7:6] == 0) ? 3'b000 : 3'(1 << (e_c[7:6] - 1));
            end
        end
        if (!fp_n) begin
            pos = 0; syn = 1;
        end else if (syn) begin
            pos = (pos + 1) % 512;
        end
        if (syn && pos == 0) begin
            s_d = tx_d; s_b1 = tx_b1; s_b2 = tx_b2;
            s_c = stat_bank[old_sel*8 +: 8];
        end
        ch = pos / 16;
        b  = (pos / 2) % 8;
        rm = syn ? role(0, dual, ch) : 0;
        ra = syn ? role(1, dual, ch) : 0;
        mbyte  = role_byte(rm);
        abyte  = role_byte(ra);
        e_moe  = (rm != 0);
        e_aoe  = (ra != 0);
        e_mout = e_moe && mbyte[7-b];
        e_aout = e_aoe && abyte[7-b];
        e_dfp  = !(syn && pos == (dual ? 15 : 63));
    endtask

    task automatic check(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        string tm, tr;
        tm = !rst_n ? "R11" : (!syn ? "R2" : (dual ? "R4 R6 R7" : "R3 R6 R7 R5"));
        tr = !rst_n ? "R11" : "R5 R8";
        check(tm, "main_oe", main_oe, e_moe);
        check(tm, "aux_oe", aux_oe, e_aoe);
        if (e_moe) check(tm, "main_out", main_out, e_mout);
        if (e_aoe) check(tm, "aux_out", aux_out, e_aout);
        check(!rst_n ? "R11" : "R10 R1", "dfp_n", dfp_n, e_dfp);
        check(!rst_n ? "R11" : (!syn ? "R2" : "R8"), "rx_strobe", rx_strobe, e_strobe);
        check(!rst_n ? "R11" : "R7", "rx_d", rx_d, e_d);
        check(tr, "rx_c", rx_c, e_c);
        check(tr, "rx_b1", rx_b1, e_b1);
        check(tr, "rx_b2", rx_b2, e_b2);
        check(!rst_n ? "R11" : "R9", "ctrl_wr", ctrl_wr, e_ctrl);
        check(!rst_n ? "R11" : "R9", "stat_sel", stat_sel, e_sel);
    endtask

    task automatic cycle(input bit rv, input bit fv);
        @(negedge clk);
        rst_n     = rv;
        fp_n      = fv;
        main_in   = 1'($urandom);
        aux_in    = 1'($urandom);
        tx_d      = 2'($urandom);    // R6: transmit sources change every cycle
        tx_b1     = 8'($urandom);
        tx_b2     = 8'($urandom);
        stat_bank = $urandom;
        @(posedge clk);
        model_update();
        #2;
        compare();
    endtask

    task automatic frames(input int n);
        for (int f = 0; f < n; f++) begin
            cycle(1, 0);
            repeat (511) cycle(1, 1);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mb[i] = 8'h00;
            ab[i] = 8'h00;
        end
        repeat (5) cycle(0, 1);         // R11 reset state
        repeat (100) cycle(1, 1);       // R2 no drive before first pulse
        frames(6);                      // R3 single mapping
        repeat (1024) cycle(1, 1);      // R1 free-running wrap
        repeat (300) cycle(1, 1);
        frames(2);                      // R1 early realignment
        dual = 1'b1;
        frames(6);                      // R4 dual mapping
        repeat (3) cycle(0, 1);         // R11 reset mid-run
        repeat (50) cycle(1, 1);        // R2 again
        frames(3);
        dual = 1'b0;
        frames(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule